// File: doc/BRIEF.md
# Clock generator configuration register bank

This block holds the control state of a multi-output clock generator. While reset is high it samples four frequency-select strap inputs every cycle. When reset falls it keeps the last sampled value. After that, the strap pins are free to serve other duties. A small serial-slave front end, which is not part of this block, delivers single-byte register accesses. The block sees each access as an address, a data byte and a write or read strobe.

The block has four byte registers:

- **Byte 0** is the control byte. It selects the frequency code, from the latched straps or from register bits. It also holds the spread-spectrum enable, the spread mode and a global tristate request.
- **Byte 1** holds the CPU and free-running SDRAM output enables.
- **Byte 2** holds the PCI output enables.
- **Byte 3** holds the remaining SDRAM output enables.

The block decodes the effective 4-bit frequency code into a CPU/PCI frequency pair, given in units of 10 kHz. It drives the enable vectors to the output buffers.

Top module: `clkcfg_regbank`

## Requirements
- R1: While `rst` is high the strap inputs are sampled every cycle. After `rst` falls the latched value holds until the next reset. Reset values:
  - byte 0 reads 0x34. This is revision ID 4'b1011 placed as bit 2 = ID[3] and bits 6:4 = ID[2:0].
  - bytes 1 to 3 have every enable at 1.
  - `rdata` is 0x00.
- R2: `freq_code` follows byte 0 bit 3. When the bit is 0 it is the latched strap value. When the bit is 1 it is {bit 2, bit 6, bit 5, bit 4} of byte 0, with bit 2 as the MSB.
- R3: `cpu_f10k`/`pci_f10k` give the CPU/PCI frequencies of `freq_code` in 10 kHz units. The table has 16 entries, for example code 0 gives 12400/4133, code 8 gives 10000/3333, code 12 gives 9000/3000 and code 15 gives 6000/3000.
- R4: `ss_en` is byte 0 bit 1 and `ss_down` is byte 0 bit 7. A write to byte 0 with bit 1 = 0 stores bit 7 as 0, so `ss_down` is never 1 while `ss_en` is 0.
- R5: `out_tristate` is byte 0 bit 0.
- R6: Output enable mapping:
  - `cpu_oe` = {byte1[6], byte1[2:0]}.
  - `sdram_oe` = {byte3[7:0], byte1[3]}.
  - `pci_oe` = {byte2[6], byte2[4:0]}.
- R7: Byte 1 bit 7 reads the inverted latched strap bit 2. Byte 2 bit 7 reads the inverted latched strap bit 0. Writes to these bits are ignored. Reserved bits (byte 1 bits 5:4, byte 2 bit 5) always read 1.
- R8: A read from an address of 4 or more returns 0xFF. A write to such an address changes no register.
- R9: When `rd_en` is high at a clock edge, `rdata` takes the value of the addressed register as it was before any write in that same cycle. Otherwise `rdata` holds its value.
- R10: A register write at a clock edge is visible on the decoded outputs right after that edge. There is no further pipeline delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the strap sampling window |
| strap_fs | input | 4 | Frequency-select strap levels |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| freq_code | output | 4 | Effective frequency code |
| cpu_f10k | output | 14 | CPU frequency, 10 kHz units |
| pci_f10k | output | 14 | PCI frequency, 10 kHz units |
| ss_en | output | 1 | Spread-spectrum enable |
| ss_down | output | 1 | Spread mode: 1 down spread, 0 center spread |
| out_tristate | output | 1 | Tristate all clock outputs |
| cpu_oe | output | 4 | CPU clock enables |
| sdram_oe | output | 9 | SDRAM clock enables |
| pci_oe | output | 6 | PCI clock enables |

## Verification
The assertions check the following on every cycle:

- the held strap latch after reset;
- that down spread never appears without spread enabled;
- fixed table anchors;
- 0xFF on reads of unmapped addresses;
- reserved bits reading as 1.

The bench's scenarios cover the rest:

- the switch of frequency source on bit 3;
- the full 16-code table sweep;
- the inverted strap readback under two strap patterns;
- ignored writes to strap and unmapped locations.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int DATA_W    = 8;
    localparam int NUM_BYTES = 4;
    localparam int CODE_W    = 4;
    localparam int FREQ_W    = 14;
    localparam int EN_BYTES  = NUM_BYTES - 1;

    // Field order follows bit 7 down to bit 0 of the control byte.
    typedef struct packed {
        logic       ss_down;
        logic [2:0] code_lo;
        logic       code_src;
        logic       code_hi;
        logic       ss_en;
        logic       tristate;
    } ctrl_t;

    typedef struct packed {
        logic [FREQ_W-1:0] cpu;
        logic [FREQ_W-1:0] pci;
    } freq_pair_t;

    function automatic freq_pair_t freq_lookup(input logic [CODE_W-1:0] code);
        freq_pair_t f;
        case (code)
            4'h0: f = '{cpu: 14'd12400, pci: 14'd4133};
            4'h1: f = '{cpu: 14'd12000, pci: 14'd4000};
            4'h2: f = '{cpu: 14'd11499, pci: 14'd3833};
            4'h3: f = '{cpu: 14'd10999, pci: 14'd3666};
            4'h4: f = '{cpu: 14'd10500, pci: 14'd3500};
            4'h5: f = '{cpu: 14'd8331,  pci: 14'd4165};
            4'h6: f = '{cpu: 14'd8000,  pci: 14'd4000};
            4'h7: f = '{cpu: 14'd7500,  pci: 14'd3750};
            4'h8: f = '{cpu: 14'd10000, pci: 14'd3333};
            4'h9: f = '{cpu: 14'd9519,  pci: 14'd3173};
            4'hA: f = '{cpu: 14'd8331,  pci: 14'd2777};
            4'hB: f = '{cpu: 14'd9700,  pci: 14'd3233};
            4'hC: f = '{cpu: 14'd9000,  pci: 14'd3000};
            4'hD: f = '{cpu: 14'd7000,  pci: 14'd3500};
            4'hE: f = '{cpu: 14'd6682,  pci: 14'd3341};
            default: f = '{cpu: 14'd6000, pci: 14'd3000};
        endcase
        return f;
    endfunction

    // Writable bits of each enable byte; the others are held at 1.
    function automatic logic [DATA_W-1:0] en_wmask(input int byte_addr);
        case (byte_addr)
            1:       return 8'h4F;
            2:       return 8'h5F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic ctrl_t ctrl_reset(input logic [CODE_W-1:0] rev);
        ctrl_t c;
        c          = '0;
        c.code_hi  = rev[3];
        c.code_lo  = rev[2:0];
        return c;
    endfunction

    // Down spread is only kept when spreading is on.
    function automatic ctrl_t ctrl_sanitize(input ctrl_t c);
        ctrl_t r;
        r = c;
        if (!c.ss_en) r.ss_down = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/clkcfg_strap_latch.sv
module clkcfg_strap_latch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] strap_in,
    output logic [W-1:0] strap_q
);
    always_ff @(posedge clk) begin
        if (rst) strap_q <= strap_in;
    end
endmodule

// File: rtl/clkcfg_ctrl_reg.sv
module clkcfg_ctrl_reg
    import clkcfg_pkg::*;
#(
    parameter logic [CODE_W-1:0] REV_ID = 4'b1011
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst)     ctrl_q <= ctrl_reset(REV_ID);
        else if (we) ctrl_q <= ctrl_sanitize(ctrl_t'(wdata));
    end
endmodule

// File: rtl/clkcfg_en_byte.sv
module clkcfg_en_byte
    import clkcfg_pkg::*;
#(
    parameter logic [DATA_W-1:0] WMASK = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '1;
        else if (we) q <= (wdata & WMASK) | ~WMASK;
    end
endmodule

// File: rtl/clkcfg_freq_sel.sv
module clkcfg_freq_sel
    import clkcfg_pkg::*;
(
    input  ctrl_t             ctrl,
    input  logic [CODE_W-1:0] strap_q,
    output logic [CODE_W-1:0] code,
    output freq_pair_t        freq
);
    always_comb begin
        code = ctrl.code_src ? {ctrl.code_hi, ctrl.code_lo} : strap_q;
        freq = freq_lookup(code);
    end
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
    import clkcfg_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter logic [CODE_W-1:0] REV_ID = 4'b1011
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CODE_W-1:0]   strap_fs,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [CODE_W-1:0]   freq_code,
    output logic [FREQ_W-1:0]   cpu_f10k,
    output logic [FREQ_W-1:0]   pci_f10k,
    output logic                ss_en,
    output logic                ss_down,
    output logic                out_tristate,
    output logic [3:0]          cpu_oe,
    output logic [8:0]          sdram_oe,
    output logic [5:0]          pci_oe
);
    logic [CODE_W-1:0] strap_q;
    ctrl_t             ctrl_q;
    freq_pair_t        freq;
    logic [DATA_W-1:0] en_q [EN_BYTES];
    logic [DATA_W-1:0] rd_mux;

    clkcfg_strap_latch #(.W(CODE_W)) strap_i (
        .clk(clk), .rst(rst), .strap_in(strap_fs), .strap_q(strap_q)
    );

    clkcfg_ctrl_reg #(.REV_ID(REV_ID)) ctrl_i (
        .clk(clk), .rst(rst),
        .we(wr_en && addr == ADDR_W'(0)),
        .wdata(wdata), .ctrl_q(ctrl_q)
    );

    for (genvar i = 0; i < EN_BYTES; i++) begin : g_en
        clkcfg_en_byte #(.WMASK(en_wmask(i + 1))) en_i (
            .clk(clk), .rst(rst),
            .we(wr_en && addr == ADDR_W'(i + 1)),
            .wdata(wdata), .q(en_q[i])
        );
    end

    clkcfg_freq_sel sel_i (
        .ctrl(ctrl_q), .strap_q(strap_q), .code(freq_code), .freq(freq)
    );

    // Bit 7 of the enable bytes is stored as 1, so XOR with a strap bit
    // returns that strap bit inverted.
    always_comb begin
        case (addr)
            ADDR_W'(0): rd_mux = ctrl_q;
            ADDR_W'(1): rd_mux = en_q[0] ^ {strap_q[2], 7'b0};
            ADDR_W'(2): rd_mux = en_q[1] ^ {strap_q[0], 7'b0};
            ADDR_W'(3): rd_mux = en_q[2];
            default:    rd_mux = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign cpu_f10k     = freq.cpu;
    assign pci_f10k     = freq.pci;
    assign ss_en        = ctrl_q.ss_en;
    assign ss_down      = ctrl_q.ss_down;
    assign out_tristate = ctrl_q.tristate;
    assign cpu_oe       = {en_q[0][6], en_q[0][2:0]};
    assign sdram_oe     = {en_q[2], en_q[0][3]};
    assign pci_oe       = {en_q[1][6], en_q[1][4:0]};
endmodule

// File: rtl/clkcfg_regbank_chk.sv
module clkcfg_regbank_chk
    import clkcfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   rdata,
    input logic                ss_en,
    input logic                ss_down,
    input logic [CODE_W-1:0]   freq_code,
    input logic [FREQ_W-1:0]   cpu_f10k,
    input logic [FREQ_W-1:0]   pci_f10k,
    input logic [CODE_W-1:0]   strap_q
);
    a_r1_strap_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(strap_q));

    a_r4_down_needs_ss: assert property (@(posedge clk) disable iff (rst)
        ss_down |-> ss_en);

    a_r3_anchor_c: assert property (@(posedge clk) disable iff (rst)
        freq_code == 4'hC |-> (cpu_f10k == 14'd9000 && pci_f10k == 14'd3000));

    a_r3_anchor_0: assert property (@(posedge clk) disable iff (rst)
        freq_code == 4'h0 |-> (cpu_f10k == 14'd12400 && pci_f10k == 14'd4133));

    a_r8_unmapped_ff: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr >= ADDR_W'(NUM_BYTES)) |=> rdata == 8'hFF);

    a_r7_reserved_one: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_W'(1)) |=> rdata[5:4] == 2'b11);
endmodule

bind clkcfg_regbank clkcfg_regbank_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdata(rdata),
    .ss_en(ss_en), .ss_down(ss_down), .freq_code(freq_code),
    .cpu_f10k(cpu_f10k), .pci_f10k(pci_f10k), .strap_q(strap_q)
);

// File: tb/clkcfg_regbank_tb_top.sv
module clkcfg_regbank_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic [3:0] strap = 4'b0101;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic [3:0] freq_code;
    logic [13:0] cpu_f10k, pci_f10k;
    logic ss_en, ss_down, out_tristate;
    logic [3:0] cpu_oe;
    logic [8:0] sdram_oe;
    logic [5:0] pci_oe;

    clkcfg_regbank dut_i (
        .clk(clk), .rst(rst), .strap_fs(strap), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .freq_code(freq_code),
        .cpu_f10k(cpu_f10k), .pci_f10k(pci_f10k), .ss_en(ss_en),
        .ss_down(ss_down), .out_tristate(out_tristate), .cpu_oe(cpu_oe),
        .sdram_oe(sdram_oe), .pci_oe(pci_oe)
    );

    int errs = 0, checks = 0;
    bit done = 0, cmp_on = 0;
    int cpu_tbl[16] = '{12400, 12000, 11499, 10999, 10500, 8331, 8000, 7500,
                        10000, 9519, 8331, 9700, 9000, 7000, 6682, 6000};
    int pci_tbl[16] = '{4133, 4000, 3833, 3666, 3500, 4165, 4000, 3750,
                        3333, 3173, 2777, 3233, 3000, 3500, 3341, 3000};

    // Behavioural reference state
    logic [3:0] m_strap;
    logic [7:0] m_b0, m_e1, m_e2, m_e3, m_rd;

    function automatic logic [7:0] m_read(input logic [7:0] a);
        case (a)
            8'd0:    return m_b0;
            8'd1:    return {~m_strap[2], m_e1[6:0]};
            8'd2:    return {~m_strap[0], m_e2[6:0]};
            8'd3:    return m_e3;
            default: return 8'hFF;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_strap = strap; m_b0 = 8'h34;
            m_e1 = 8'hFF; m_e2 = 8'hFF; m_e3 = 8'hFF; m_rd = 8'h00;
        end else begin
            if (rd_en) m_rd = m_read(addr);
            if (wr_en) begin
                case (addr)
                    8'd0: m_b0 = wdata[1] ? wdata : (wdata & 8'h7F);
                    8'd1: m_e1 = wdata | 8'hB0;
                    8'd2: m_e2 = wdata | 8'hA0;
                    8'd3: m_e3 = wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Full comparison against the reference on every clock
    always @(negedge clk) if (cmp_on) begin
        logic [3:0] ec;
        ec = m_b0[3] ? {m_b0[2], m_b0[6:4]} : m_strap;
        chk(freq_code == ec, "R2", "freq_code", freq_code, ec);
        chk(cpu_f10k == 14'(cpu_tbl[ec]) && pci_f10k == 14'(pci_tbl[ec]), "R3",
            "cpu/pci", {cpu_f10k, pci_f10k}, {14'(cpu_tbl[ec]), 14'(pci_tbl[ec])});
        chk(ss_en == m_b0[1] && ss_down == m_b0[7], "R4", "ss_en/ss_down",
            {ss_en, ss_down}, {m_b0[1], m_b0[7]});
        chk(out_tristate == m_b0[0], "R5", "out_tristate", out_tristate, m_b0[0]);
        chk(cpu_oe == {m_e1[6], m_e1[2:0]} && sdram_oe == {m_e3, m_e1[3]} &&
            pci_oe == {m_e2[6], m_e2[4:0]}, "R6", "enables",
            {cpu_oe, sdram_oe, pci_oe},
            {m_e1[6], m_e1[2:0], m_e3, m_e1[3], m_e2[6], m_e2[4:0]});
        chk(rdata == m_rd, "R9", "rdata", rdata, m_rd);
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
        #1 chk(rdata == exp, tag, $sformatf("read addr %0d", a), rdata, exp);
    endtask

    task automatic do_reset(input logic [3:0] s);
        @(negedge clk); rst = 1'b1; strap = s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp_on = 1;
        rst = 1'b0;
        @(negedge clk); strap = 4'b1100;           // R1: latched value must hold
        #1 chk(rdata == 8'h00, "R1", "rdata after reset", rdata, 8'h00);
        chk(freq_code == 4'b0101, "R1", "held strap code", freq_code, 4'b0101);
        chk(cpu_f10k == 14'd8331 && pci_f10k == 14'd4165, "R3", "strap 0101 pair",
            {cpu_f10k, pci_f10k}, {14'd8331, 14'd4165});
        rd(8'd0, 8'h34, "R1");
        rd(8'd1, 8'h7F, "R7");
        rd(8'd2, 8'h7F, "R7");
        rd(8'd3, 8'hFF, "R1");
        rd(8'h20, 8'hFF, "R8");

        // R2/R3: register-sourced code sweep over all 16 codes
        for (int c = 0; c < 16; c++) begin
            wr(8'd0, {1'b0, 3'(c), 1'b1, 1'(c >> 3), 2'b00});
            #1 chk(freq_code == 4'(c), "R10", "code after write", freq_code, c);
            chk(cpu_f10k == 14'(cpu_tbl[c]), "R3", "cpu table", cpu_f10k, cpu_tbl[c]);
        end
        wr(8'd0, 8'h70);                           // back to strap source
        #1 chk(freq_code == 4'b0101, "R2", "strap source", freq_code, 4'b0101);

        wr(8'd0, 8'h80);  rd(8'd0, 8'h00, "R4");   // down spread dropped
        wr(8'd0, 8'h82);  rd(8'd0, 8'h82, "R4");
        #1 chk(ss_down && ss_en, "R4", "down spread on", {ss_en, ss_down}, 2'b11);
        wr(8'd0, 8'h01);
        #1 chk(out_tristate == 1'b1, "R5", "tristate", out_tristate, 1);

        wr(8'd1, 8'h00);  rd(8'd1, 8'h30, "R7");
        wr(8'd1, 8'h80);  rd(8'd1, 8'h30, "R7");   // strap bit not writable
        #1 chk(cpu_oe == 4'h0 && sdram_oe[0] == 1'b0, "R6", "cpu enables",
               {cpu_oe, sdram_oe[0]}, 0);
        wr(8'd2, 8'h00);  rd(8'd2, 8'h20, "R7");
        #1 chk(pci_oe == 6'h00, "R6", "pci enables", pci_oe, 0);
        wr(8'd3, 8'h5A);  rd(8'd3, 8'h5A, "R6");

        wr(8'd9, 8'h00);                           // R8: no register touched
        rd(8'd0, 8'h01, "R8");
        rd(8'd3, 8'h5A, "R8");
        rd(8'd9, 8'hFF, "R8");

        do_reset(4'b0011);
        @(negedge clk);
        #1 chk(freq_code == 4'b0011, "R1", "second strap latch", freq_code, 4'b0011);
        rd(8'd1, 8'hFF, "R7");
        rd(8'd2, 8'h7F, "R7");
        rd(8'd0, 8'h34, "R1");

        repeat (2) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule